// File: doc/BRIEF.md
# Auto-Reload Timer with PWM

This block is a 16-bit timer that advances by one on every system clock while it runs and its gate input is high. In plain mode the whole count reloads from a pair of reload bytes when it passes its all-ones value, so the timeout is (65536 − reload) clocks. With both reload bytes at their reset value of zero it behaves as an ordinary free-running 16-bit timer.

In PWM mode the count splits in two. The low byte is a period prescaler that restarts from the low reload byte each time it overflows. The high byte is an 8-bit ramp that advances once per prescaler overflow. The output is high while the ramp is below a duty value. Software writes the duty into the high reload byte. A shadow register holds the value in use, and it takes a new value only when the ramp wraps from FFh to 00h. This gives a frequency of fclk / (256 × (256 − low reload)) and a duty of high reload / 256.

An overflow flag and an interrupt request work in both modes. The gate input freezes the count and the output level. A port-latch input forces the output low immediately.

Top module: `arpt_timer`

## Requirements
- R1: While the run bit is 1 and `gate` is 1, the count advances by one on every clock edge, with no prescale.
- R2: In plain mode (PWM bit 0), the step taken from FFFFh loads the count with {high reload, low reload} and sets the overflow flag.
- R3: After reset the count, both reload bytes, all control bits and the flag are 0. With the default reload, a step from FFFFh gives 0000h.
- R4: In PWM mode:
  - a step with the low byte at FFh loads the low byte from the low reload and advances the high byte by one;
  - any other step advances the low byte only;
  - the flag is set when the high byte wraps from FFh to 00h;
  - one period lasts 256 × (256 − low reload) clocks.
- R5: In PWM mode `pwm_out` is 1 while the high count byte is less than the duty value in use, and 0 otherwise. Over one period it is high for duty × (256 − low reload) clocks. A duty value of 00h gives a constant 0.
- R6: While PWM mode is on, a write to the high reload changes the duty value in use only at the next high-byte wrap. While PWM mode is off, the duty value in use follows the high reload.
- R7: With `gate` at 0, the count and `pwm_out` hold their values. Counting resumes on the first edge after `gate` returns to 1.
- R8: `pin_latch` = 0 drives `pwm_out` to 0 in the same cycle. With `pin_latch` = 1 and PWM off, `pwm_out` is 1. After `pin_latch` returns to 1, the PWM level reappears.
- R9: Writing the control register with bit 3 = 0 clears the flag. Bit 3 = 1 leaves the flag as it is. A set in the same cycle wins over a clear. `irq` is the flag ANDed with the interrupt-enable bit.
- R10: Register writes take effect on the next clock edge. The address map is:
  - 0: count low
  - 1: count high
  - 2: reload low
  - 3: reload high
  - 4: control, with bit 0 run, bit 1 PWM, bit 2 interrupt enable, bit 3 flag
  
  A write to a count byte overrides counting in that cycle and leaves the other count byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (map in R10) |
| wr_data | input | 8 | Write data |
| gate | input | 1 | Count enable; 0 freezes the count and the output |
| pin_latch | input | 1 | Port-latch bit; 0 forces `pwm_out` low |
| count_o | output | 16 | Current count, {high byte, low byte} |
| pwm_out | output | 1 | Timer output pin |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default byte width of 8, so the count is the full 16 bits. It sets the low reload to FEh, which shortens a PWM period to 512 clocks. At that length, whole periods can be counted cycle by cycle for the duty checks, and several ramp wraps fit in one short run. This makes the buffered duty update and the constant-low zero duty observable. Plain-mode wraps are reached by writing the count to just below FFFFh.

// File: rtl/arpt_pkg.sv
package arpt_pkg;
  typedef enum logic [2:0] {
    SEL_CNT_LO = 3'd0,
    SEL_CNT_HI = 3'd1,
    SEL_REL_LO = 3'd2,
    SEL_REL_HI = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_PWM  = 1;
  localparam int CTRL_IEN  = 2;
  localparam int CTRL_FLAG = 3;
endpackage

// File: rtl/arpt_regs.sv
module arpt_regs
  import arpt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wrap,
  output logic              run,
  output logic              pwm_mode,
  output logic              irq_en,
  output logic              flag,
  output logic [BYTE_W-1:0] rel_lo,
  output logic [BYTE_W-1:0] rel_hi,
  output logic              ld_lo,
  output logic              ld_hi
);
  reg_sel_e sel;
  logic     wr_ctrl;

  always_comb begin
    sel     = reg_sel_e'(wr_addr);
    ld_lo   = wr_en && (sel == SEL_CNT_LO);
    ld_hi   = wr_en && (sel == SEL_CNT_HI);
    wr_ctrl = wr_en && (sel == SEL_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      pwm_mode <= 1'b0;
      irq_en   <= 1'b0;
      rel_lo   <= '0;
      rel_hi   <= '0;
    end else if (wr_en) begin
      if (sel == SEL_REL_LO) rel_lo <= wr_data;
      if (sel == SEL_REL_HI) rel_hi <= wr_data;
      if (sel == SEL_CTRL) begin
        run      <= wr_data[CTRL_RUN];
        pwm_mode <= wr_data[CTRL_PWM];
        irq_en   <= wr_data[CTRL_IEN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              flag <= 1'b0;
    else if (wrap)                           flag <= 1'b1;
    else if (wr_ctrl && !wr_data[CTRL_FLAG]) flag <= 1'b0;
  end

  a_r9_flag_set : assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);
  a_r9_flag_clear : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wr_data[CTRL_FLAG] && !wrap) |=> !flag);
endmodule

// File: rtl/arpt_counter.sv
module arpt_counter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              pwm_mode,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [BYTE_W-1:0] ld_val,
  input  logic [BYTE_W-1:0] rel_lo,
  input  logic [BYTE_W-1:0] rel_hi,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              wrap
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] BMAX = {BYTE_W{1'b1}};

  logic              lo_full, hi_full, loading;
  logic [BYTE_W-1:0] nx_lo, nx_hi;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    lo_full = (cnt_lo == BMAX);
    hi_full = (cnt_hi == BMAX);
    loading = ld_lo || ld_hi;
    wrap    = step_en && !loading && lo_full && hi_full;
    cnt     = {cnt_hi, cnt_lo};
    nx_lo   = cnt_lo;
    nx_hi   = cnt_hi;
    if (loading) begin
      if (ld_lo) nx_lo = ld_val;
      if (ld_hi) nx_hi = ld_val;
    end else if (step_en) begin
      if (pwm_mode) begin
        if (lo_full) begin
          nx_lo = rel_lo;
          nx_hi = cnt_hi + 1'b1;
        end else begin
          nx_lo = cnt_lo + 1'b1;
        end
      end else if (lo_full && hi_full) begin
        nx_lo = rel_lo;
        nx_hi = rel_hi;
      end else begin
        {nx_hi, nx_lo} = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= nx_lo;
      cnt_hi <= nx_hi;
    end
  end

  a_r1_step : assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !loading && !pwm_mode && !(lo_full && hi_full))
      |=> ({cnt_hi, cnt_lo} == CNT_W'($past(cnt) + 1'b1)));
  a_r2_reload : assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !loading && !pwm_mode && lo_full && hi_full)
      |=> ({cnt_hi, cnt_lo} == $past({rel_hi, rel_lo})));
  a_r4_prescale_carry : assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !loading && pwm_mode && lo_full)
      |=> (cnt_lo == $past(rel_lo)) && (cnt_hi == BYTE_W'($past(cnt_hi) + 1'b1)));
  a_r7_gate_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !loading) |=> $stable({cnt_hi, cnt_lo}));
endmodule

// File: rtl/arpt_duty.sv
module arpt_duty #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_mode,
  input  logic              wrap,
  input  logic [BYTE_W-1:0] rel_hi,
  input  logic [BYTE_W-1:0] cnt_hi,
  input  logic              pin_latch,
  output logic              pwm_out
);
  logic [BYTE_W-1:0] duty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 duty_q <= '0;
    else if (!pwm_mode || wrap) duty_q <= rel_hi;
  end

  always_comb pwm_out = pin_latch && (!pwm_mode || (cnt_hi < duty_q));

  a_r6_duty_held : assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !wrap) |=> $stable(duty_q));
  a_r5_zero_low : assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && duty_q == '0) |-> !pwm_out);
  a_r8_latch_low : assert property (@(posedge clk) disable iff (!rst_n)
    !pin_latch |-> !pwm_out);
endmodule

// File: rtl/arpt_timer.sv
module arpt_timer #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              gate,
  input  logic              pin_latch,
  output logic [CNT_W-1:0]  count_o,
  output logic              pwm_out,
  output logic              ovf_flag,
  output logic              irq
);
  logic              run, pwm_mode, irq_en, wrap, ld_lo, ld_hi, step_en;
  logic [BYTE_W-1:0] rel_lo, rel_hi, cnt_lo, cnt_hi;

  always_comb step_en = run && gate;

  arpt_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wrap(wrap), .run(run), .pwm_mode(pwm_mode),
    .irq_en(irq_en), .flag(ovf_flag), .rel_lo(rel_lo), .rel_hi(rel_hi),
    .ld_lo(ld_lo), .ld_hi(ld_hi)
  );

  arpt_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .pwm_mode(pwm_mode),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_val(wr_data), .rel_lo(rel_lo),
    .rel_hi(rel_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .wrap(wrap)
  );

  arpt_duty #(.BYTE_W(BYTE_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .wrap(wrap),
    .rel_hi(rel_hi), .cnt_hi(cnt_hi), .pin_latch(pin_latch),
    .pwm_out(pwm_out)
  );

  always_comb begin
    count_o = {cnt_hi, cnt_lo};
    irq     = ovf_flag && irq_en;
  end

  a_r9_irq_needs_flag : assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
endmodule

// File: tb/sim_arpt_timer.sv
module sim_arpt_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        gate = 1'b1;
  logic        pin_latch = 1'b1;
  logic [15:0] count_o;
  logic        pwm_out, ovf_flag, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  arpt_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gate(gate), .pin_latch(pin_latch),
    .count_o(count_o), .pwm_out(pwm_out), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_hi(input logic [7:0] v);
    while (count_o[15:8] != v) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R3 count at reset", count_o, 16'h0000);
    chk("R3 flag at reset", ovf_flag, 1'b0);
    chk("R9 irq at reset", irq, 1'b0);
    chk("R8 out follows latch, PWM off", pwm_out, 1'b1);
    pin_latch = 1'b0; #1;
    chk("R8 latch low forces out low", pwm_out, 1'b0);
    pin_latch = 1'b1; #1;
  endtask

  task automatic t_free_run;
    wr(3'd4, 8'h01);
    tick(5);
    chk("R1 one step per clock", count_o, 16'h0005);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'hFF);
    wr(3'd4, 8'h01);
    chk("R3 count before wrap", count_o, 16'hFFFF);
    tick(1);
    chk("R3 default reload wraps to zero", count_o, 16'h0000);
    chk("R2 flag set on wrap", ovf_flag, 1'b1);
  endtask

  task automatic t_write_priority;
    wr(3'd1, 8'h12);
    chk("R10 count write overrides step", count_o, 16'h1200);
    tick(1);
    chk("R10 counting resumes after write", count_o, 16'h1201);
  endtask

  task automatic t_flag_irq;
    chk("R9 irq masked by enable", irq, 1'b0);
    wr(3'd4, 8'h0D);
    chk("R9 flag bit 1 keeps flag", ovf_flag, 1'b1);
    chk("R9 irq with enable", irq, 1'b1);
    wr(3'd4, 8'h05);
    chk("R9 flag cleared by write of 0", ovf_flag, 1'b0);
    chk("R9 irq drops with flag", irq, 1'b0);
  endtask

  task automatic t_plain_reload;
    wr(3'd4, 8'h04);
    wr(3'd2, 8'h34);
    wr(3'd3, 8'h12);
    wr(3'd0, 8'hFD);
    wr(3'd1, 8'hFF);
    wr(3'd4, 8'h05);
    tick(2);
    chk("R2 count at FFFF", count_o, 16'hFFFF);
    chk("R2 no flag before wrap", ovf_flag, 1'b0);
    tick(1);
    chk("R2 reload from pair", count_o, 16'h1234);
    chk("R2 flag on reload", ovf_flag, 1'b1);
    chk("R9 irq on reload", irq, 1'b1);
  endtask

  task automatic t_pwm_period;
    int highs = 0;
    wr(3'd4, 8'h00);
    wr(3'd2, 8'hFE);
    wr(3'd3, 8'h40);
    wr(3'd0, 8'hFE);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h03);
    for (int i = 0; i < 512; i++) begin
      if (pwm_out) highs++;
      if (i == 1) chk("R4 low byte steps FE to FF", count_o, 16'h00FF);
      if (i == 2) chk("R4 low reload and high advance", count_o, 16'h01FE);
      if (i == 510) chk("R4 no flag mid-period", ovf_flag, 1'b0);
      tick(1);
    end
    chk("R5 high time for duty 40h", highs, 128);
    chk("R4 flag on ramp wrap", ovf_flag, 1'b1);
    chk("R4 period of 512 clocks", count_o, 16'h00FE);
  endtask

  task automatic t_duty_buffer;
    wait_hi(8'h10);
    wr(3'd3, 8'h80);
    wait_hi(8'h60);
    chk("R6 old duty kept until wrap", pwm_out, 1'b0);
    wait_hi(8'h00);
    wait_hi(8'h60);
    chk("R6 new duty after wrap", pwm_out, 1'b1);
  endtask

  task automatic t_latch;
    pin_latch = 1'b0; #1;
    chk("R8 latch forces low at once", pwm_out, 1'b0);
    tick(2);
    chk("R8 stays low while latch 0", pwm_out, 1'b0);
    pin_latch = 1'b1; #1;
    chk("R8 level back after latch 1", pwm_out, 1'b1);
  endtask

  task automatic t_gate;
    logic [15:0] snap;
    gate = 1'b0;
    snap = count_o;
    tick(20);
    chk("R7 count frozen by gate", count_o, snap);
    chk("R7 output frozen by gate", pwm_out, 1'b1);
    gate = 1'b1;
    tick(1);
    chk("R7 counting resumes", count_o != snap, 1'b1);
  endtask

  task automatic t_zero_duty;
    int highs = 0;
    wr(3'd3, 8'h00);
    wait_hi(8'h00);
    for (int i = 0; i < 512; i++) begin
      if (pwm_out) highs++;
      tick(1);
    end
    chk("R5 zero duty constant low", highs, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    t_reset();
    t_free_run();
    t_write_priority();
    t_flag_irq();
    t_plain_reload();
    t_pwm_period();
    t_duty_buffer();
    t_latch();
    t_gate();
    t_zero_duty();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule